// File: doc/BRIEF.md
# Fractional-Period Tick Timer

This block is a 32-bit up-counting timer driven by a slow-clock strobe. Software programs it through a small word-addressed register bus. The counter advances on qualified ticks. A tick is either every strobe or one strobe out of a power-of-two group. When the counter passes its all-ones value, it either reloads from a load register or halts. Three event sources set sticky status flags: reaching a match value, overflow, and an external capture pulse. A single level interrupt reflects the flags that software has enabled.

The block's distinguishing feature is a signed phase accumulator that moves on every corrected overflow. Its sign decides whether the next period takes the plain reload value or starts one count lower, which lengthens that period by one tick. Two programmable increments set the long-run ratio of lengthened periods to plain ones. An integer reload can therefore produce an exact non-integer mean period. One example is 32.768 strobes per period, which gives exactly 1 ms from a 32768 Hz strobe.

Top module: `ftick_timer`

## Requirements
- R1: After synchronous reset every register reads zero, the accumulator is zero and `irq` is low.
- R2: Register word offsets are:
  - 0: control. Bit0 is run, bit1 is auto-reload, bit2 is prescale enable, bits5:3 are the divider select, bit6 is match enable and bit7 is correction enable.
  - 1: counter.
  - 2: load.
  - 3: trigger (write-only, reads zero).
  - 4: match value.
  - 5: status.
  - 6: interrupt enable.
  - 7: capture (read-only).
  - 8: positive increment.
  - 9: negative increment.

  Status and interrupt enable share the same bit layout: bit0 is match, bit1 is overflow and bit2 is capture. Both increments read back sign-extended from the accumulator width.
- R3: A counter write sets the counter in the next cycle and clears the prescaler phase. While run is clear, strobes leave the counter unchanged. Once run is set, the first tick counts up from the written value.
- R4: With prescale enable clear, each strobe taken while running is one tick. With it set, one tick occurs every 2^(sel+1) strobes, where sel is the divider select.
- R5: With auto-reload set, a tick at 0xFFFFFFFF loads the load value, or that value minus one (see R11), and sets the overflow flag. A load of 0x100000000−N therefore gives N ticks per plain period.
- R6: With auto-reload clear, a tick at 0xFFFFFFFF wraps the counter to 0, clears run and sets the overflow flag. Further strobes do not change the counter.
- R7: A trigger write copies the load register into the counter in the next cycle. A counter write or trigger write takes priority over a tick in the same cycle.
- R8: With match enable set, a tick that brings the counter to the match value sets the match flag.
- R9: A capture pulse copies the counter into the capture register and sets the capture flag.
- R10: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. An event in the same cycle wins over the clear.
- R11: With correction enabled, each auto-reload overflow checks the accumulator sign first. If it is negative, the reload is one lower and the positive increment is added. Otherwise the plain reload is used and the negative increment is added. Clearing correction enable holds the accumulator at zero, and every period is then exactly N.
- R12: With N=32, positive increment 232000 and negative increment −768000, the overflow periods from a zero accumulator run 32, 33, and so on. The 1000 periods after the first overflow total exactly 32768 strobes.
- R13: `irq` is high exactly when some status flag and its enable bit are both set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Slow-clock strobe, one cycle per input tick |
| cap_pulse | input | 1 | Capture event, one cycle wide |
| we | input | 1 | Register write enable |
| addr | input | 4 | Register word offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The bound checker watches four behaviours on every cycle:
- the counter freezes while stopped;
- counter and trigger writes take effect one cycle later;
- an auto-reload overflow lands on the load value or one below it and raises the overflow flag;
- a one-shot overflow wraps to zero and drops run.

It also checks that a write-one-to-clear removes the overflow flag. Only the bench scenarios can show the following:
- the prescale ratios;
- the sequence of stretched and plain periods;
- the exact 32768-strobe total over 1000 corrected periods;
- match timing;
- capture contents;
- interrupt masking.

// File: rtl/ftick_pkg.sv
package ftick_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned ADDR_W = 4;
    localparam int unsigned DIV_W  = 3;
    localparam int unsigned PRE_W  = 1 << DIV_W;
    localparam int unsigned FLAG_N = 3;

    localparam int unsigned FL_MAT = 0;
    localparam int unsigned FL_OVF = 1;
    localparam int unsigned FL_CAP = 2;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL  = 4'd0,
        RA_COUNT = 4'd1,
        RA_LOAD  = 4'd2,
        RA_TRIG  = 4'd3,
        RA_MATCH = 4'd4,
        RA_STAT  = 4'd5,
        RA_IEN   = 4'd6,
        RA_CAPT  = 4'd7,
        RA_PINC  = 4'd8,
        RA_NINC  = 4'd9
    } reg_addr_e;

    typedef struct packed {
        logic             corr_en;
        logic             match_en;
        logic [DIV_W-1:0] div_sel;
        logic             pre_en;
        logic             reload_en;
        logic             run;
    } ctrl_t;

    localparam int unsigned CTRL_W = $bits(ctrl_t);

    // last phase value of a prescale group of 2^(sel+1) strobes
    function automatic logic [PRE_W-1:0] div_last(input logic [DIV_W-1:0] sel);
        logic [PRE_W:0] span;
        span = (PRE_W+1)'(2) << sel;
        return PRE_W'(span - 1'b1);
    endfunction

endpackage

// File: rtl/ftick_prescaler.sv
module ftick_prescaler
    import ftick_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             step_en,
    input  logic             pre_en,
    input  logic [DIV_W-1:0] div_sel,
    input  logic             clear,
    output logic             tick
);

    logic [PRE_W-1:0] phase;
    logic             wrap;

    assign wrap = (phase >= div_last(div_sel));
    assign tick = step_en && (!pre_en || wrap);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            phase <= '0;
        end else if (step_en && pre_en) begin
            phase <= wrap ? '0 : phase + 1'b1;
        end
    end

endmodule

// File: rtl/ftick_phase_acc.sv
module ftick_phase_acc #(
    parameter int unsigned ACC_W = 24
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    hold_zero,
    input  logic                    step,
    input  logic signed [ACC_W-1:0] pos_inc,
    input  logic signed [ACC_W-1:0] neg_inc,
    output logic                    stretch
);

    logic signed [ACC_W-1:0] acc;

    // a negative phase means the next period is one tick longer
    assign stretch = acc[ACC_W-1];

    always_ff @(posedge clk) begin
        if (rst || hold_zero) begin
            acc <= '0;
        end else if (step) begin
            acc <= stretch ? acc + pos_inc : acc + neg_inc;
        end
    end

endmodule

// File: rtl/ftick_timer.sv
module ftick_timer
    import ftick_pkg::*;
#(
    parameter int unsigned ACC_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en,
    input  logic              cap_pulse,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);

    ctrl_t                   ctrl;
    logic [DATA_W-1:0]       count, load, match_val, capt;
    logic [FLAG_N-1:0]       flags, ien, evt, clr;
    logic signed [ACC_W-1:0] pinc, ninc;

    logic wr_ctrl, wr_count, wr_load, wr_trig, wr_match, wr_stat, wr_ien, wr_pinc, wr_ninc;
    logic bus_override, tick, at_top, stretch, stretch_cut;
    logic ovf_evt, mat_evt, acc_step;
    logic [DATA_W-1:0] reload_val, tick_val;

    always_comb begin
        wr_ctrl  = we && (addr == RA_CTRL);
        wr_count = we && (addr == RA_COUNT);
        wr_load  = we && (addr == RA_LOAD);
        wr_trig  = we && (addr == RA_TRIG);
        wr_match = we && (addr == RA_MATCH);
        wr_stat  = we && (addr == RA_STAT);
        wr_ien   = we && (addr == RA_IEN);
        wr_pinc  = we && (addr == RA_PINC);
        wr_ninc  = we && (addr == RA_NINC);
    end

    assign bus_override = wr_count || wr_trig;

    ftick_prescaler i_pre (
        .clk     (clk),
        .rst     (rst),
        .step_en (ctrl.run && clk_en),
        .pre_en  (ctrl.pre_en),
        .div_sel (ctrl.div_sel),
        .clear   (bus_override),
        .tick    (tick)
    );

    ftick_phase_acc #(.ACC_W(ACC_W)) i_acc (
        .clk       (clk),
        .rst       (rst),
        .hold_zero (!ctrl.corr_en),
        .step      (acc_step),
        .pos_inc   (pinc),
        .neg_inc   (ninc),
        .stretch   (stretch)
    );

    always_comb begin
        at_top      = (count == '1);
        stretch_cut = ctrl.corr_en && stretch;
        reload_val  = load - DATA_W'(stretch_cut);
        if (at_top) begin
            tick_val = ctrl.reload_en ? reload_val : '0;
        end else begin
            tick_val = count + 1'b1;
        end
        ovf_evt  = tick && at_top && !bus_override;
        mat_evt  = tick && !bus_override && ctrl.match_en && (tick_val == match_val);
        acc_step = ovf_evt && ctrl.reload_en && ctrl.corr_en;
        evt          = '0;
        evt[FL_MAT]  = mat_evt;
        evt[FL_OVF]  = ovf_evt;
        evt[FL_CAP]  = cap_pulse;
        clr = wr_stat ? wdata[FLAG_N-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (wr_count) begin
            count <= wdata;
        end else if (wr_trig) begin
            count <= load;
        end else if (tick) begin
            count <= tick_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr_ctrl) begin
            ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
        end else if (ovf_evt && !ctrl.reload_en) begin
            ctrl.run <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            load      <= '0;
            match_val <= '0;
            capt      <= '0;
            flags     <= '0;
            ien       <= '0;
            pinc      <= '0;
            ninc      <= '0;
        end else begin
            if (wr_load)   load      <= wdata;
            if (wr_match)  match_val <= wdata;
            if (wr_ien)    ien       <= wdata[FLAG_N-1:0];
            if (wr_pinc)   pinc      <= wdata[ACC_W-1:0];
            if (wr_ninc)   ninc      <= wdata[ACC_W-1:0];
            if (cap_pulse) capt      <= count;
            flags <= (flags & ~clr) | evt;
        end
    end

    assign irq = |(flags & ien);

    always_comb begin
        case (addr)
            RA_CTRL:  rdata = DATA_W'(ctrl);
            RA_COUNT: rdata = count;
            RA_LOAD:  rdata = load;
            RA_MATCH: rdata = match_val;
            RA_STAT:  rdata = DATA_W'(flags);
            RA_IEN:   rdata = DATA_W'(ien);
            RA_CAPT:  rdata = capt;
            RA_PINC:  rdata = DATA_W'(pinc);
            RA_NINC:  rdata = DATA_W'(ninc);
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/ftick_timer_chk.sv
module ftick_timer_chk
    import ftick_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              tick,
    input logic [DATA_W-1:0] count,
    input logic [DATA_W-1:0] load,
    input logic              run,
    input logic              reload_en,
    input logic              ovf_flag
);

    logic cnt_wr, trig_wr;
    assign cnt_wr  = we && (addr == 4'd1);
    assign trig_wr = we && (addr == 4'd3);

    // R3
    count_write_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> count == $past(wdata));

    // R3
    stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !cnt_wr && !trig_wr) |=> $stable(count));

    // R7
    trig_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (trig_wr && !cnt_wr) |=> count == $past(load));

    // R5
    auto_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && count == '1 && reload_en && !cnt_wr && !trig_wr)
        |=> ((count == $past(load)) || (count == $past(load) - 1'b1)) && ovf_flag);

    // R6
    one_shot_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && count == '1 && !reload_en && !we) |=> (count == '0) && !run && ovf_flag);

    // R10
    w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (we && addr == 4'd5 && wdata[1] && !tick) |=> !ovf_flag);

endmodule

bind ftick_timer ftick_timer_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .we        (we),
    .addr      (addr),
    .wdata     (wdata),
    .tick      (tick),
    .count     (count),
    .load      (load),
    .run       (ctrl.run),
    .reload_en (ctrl.reload_en),
    .ovf_flag  (flags[1])
);

// File: tb/test_ftick_timer.sv
module test_ftick_timer;
    import ftick_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clk_en = 1'b0;
    logic        cap_pulse = 1'b0;
    logic        we = 1'b0;
    logic [3:0]  addr = 4'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int st [0:1000];

    ftick_timer i_ftick_timer (
        .clk(clk), .rst(rst), .clk_en(clk_en), .cap_pulse(cap_pulse),
        .we(we), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic report();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic strobe(input int n);
        if (n > 0) begin
            @(negedge clk);
            clk_en = 1'b1;
            repeat (n) @(negedge clk);
            clk_en = 1'b0;
        end
    endtask

    function automatic logic [31:0] model_count(input logic [31:0] start,
                                                input logic [31:0] ld, input int k);
        logic [31:0] c;
        c = start;
        for (int i = 0; i < k; i++) c = (c == 32'hFFFF_FFFF) ? ld : c + 1;
        return c;
    endfunction

    // clock strobes continuously, stamp each overflow interrupt and clear it
    task automatic run_periods(input int n);
        int c = 0;
        int seen = 0;
        @(negedge clk);
        clk_en = 1'b1;
        while (seen < n) begin
            @(negedge clk);
            c++;
            we = 1'b0;
            if (irq) begin
                st[seen] = c;
                seen++;
                addr = 4'd5; wdata = 32'd2; we = 1'b1;
            end
        end
        @(negedge clk);
        we = 1'b0;
        clk_en = 1'b0;
    endtask

    initial begin
        logic [31:0] v;
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 10; a++) begin
            rd(4'(a), v);
            chk("R1 reset register", v, 32'd0);
        end
        chk("R1 irq after reset", {31'd0, irq}, 32'd0);

        // R3 counter write while stopped, hold, then count
        wr(4'd1, 32'h0000_1000);
        strobe(6);
        rd(4'd1, v); chk("R3 stopped hold", v, 32'h0000_1000);
        wr(4'd0, 32'h1);
        strobe(5);
        rd(4'd1, v); chk("R3 first ticks from written value", v, 32'h0000_1005);

        // R7 trigger, then freeze and resume
        wr(4'd2, 32'h0000_0500);
        wr(4'd3, 32'h0);
        rd(4'd1, v); chk("R7 trigger reload", v, 32'h0000_0500);
        rd(4'd3, v); chk("R2 trigger reads zero", v, 32'd0);
        wr(4'd0, 32'h0);
        strobe(4);
        rd(4'd1, v); chk("R3 freeze when run clear", v, 32'h0000_0500);
        wr(4'd0, 32'h1);
        strobe(2);
        rd(4'd1, v); chk("R3 resume", v, 32'h0000_0502);

        // R4 prescaler, directed divide by 8 and 16
        wr(4'd0, 32'h0);
        wr(4'd1, 32'h0);
        wr(4'd0, 32'h1 | 32'h4 | (32'd2 << 3));
        strobe(40);
        rd(4'd1, v); chk("R4 divide by 8", v, 32'd5);
        wr(4'd0, 32'h0);
        wr(4'd1, 32'h0);
        wr(4'd0, 32'h1 | 32'h4 | (32'd3 << 3));
        strobe(50);
        rd(4'd1, v); chk("R4 divide by 16", v, 32'd3);
        for (int i = 0; i < 6; i++) begin
            int sel = $urandom % 5;
            int k = $urandom % 120;
            wr(4'd0, 32'h0);
            wr(4'd1, 32'h0);
            wr(4'd0, 32'h1 | 32'h4 | (32'(sel) << 3));
            strobe(k);
            rd(4'd1, v); chk("R4 random prescale", v, 32'(k >> (sel + 1)));
        end

        // R5 auto-reload overflow, R13 masking, R10 write-one-to-clear
        wr(4'd0, 32'h0);
        wr(4'd2, 32'hFFFF_FFF0);
        wr(4'd1, 32'hFFFF_FFFD);
        wr(4'd0, 32'h3);
        strobe(3);
        wr(4'd0, 32'h0);
        rd(4'd1, v); chk("R5 reload on overflow", v, 32'hFFFF_FFF0);
        rd(4'd5, v); chk("R5 overflow flag", v, 32'h2);
        chk("R13 masked irq low", {31'd0, irq}, 32'd0);
        wr(4'd6, 32'h2);
        #1 chk("R13 enabled irq high", {31'd0, irq}, 32'd1);
        wr(4'd5, 32'h5);
        rd(4'd5, v); chk("R10 write zero keeps flag", v, 32'h2);
        wr(4'd5, 32'h2);
        rd(4'd5, v); chk("R10 write one clears flag", v, 32'h0);
        chk("R13 irq drops after clear", {31'd0, irq}, 32'd0);

        // R6 one-shot
        wr(4'd1, 32'hFFFF_FFFE);
        wr(4'd0, 32'h1);
        strobe(5);
        rd(4'd1, v); chk("R6 one-shot wraps and holds", v, 32'd0);
        rd(4'd0, v); chk("R6 run cleared", v, 32'd0);
        rd(4'd5, v); chk("R6 overflow flag", v, 32'h2);
        wr(4'd5, 32'h7);

        // R8 match
        wr(4'd4, 32'd100);
        wr(4'd1, 32'd95);
        wr(4'd0, 32'h41);
        strobe(4);
        rd(4'd5, v); chk("R8 no match before value", v, 32'h0);
        strobe(1);
        rd(4'd5, v); chk("R8 match flag", v, 32'h1);
        wr(4'd0, 32'h0);
        wr(4'd5, 32'h7);

        // R9 capture
        wr(4'd1, 32'h0000_1234);
        wr(4'd6, 32'h4);
        @(negedge clk) cap_pulse = 1'b1;
        @(negedge clk) cap_pulse = 1'b0;
        rd(4'd7, v); chk("R9 capture value", v, 32'h0000_1234);
        rd(4'd5, v); chk("R9 capture flag", v, 32'h4);
        chk("R13 capture irq", {31'd0, irq}, 32'd1);
        wr(4'd5, 32'h7);

        // R5 random reload periods without correction
        for (int i = 0; i < 12; i++) begin
            int n = 2 + $urandom % 30;
            int k = $urandom % 90;
            logic [31:0] ld = 32'd0 - 32'(n);
            logic [31:0] s0 = ld + 32'($urandom % n);
            wr(4'd0, 32'h0);
            wr(4'd2, ld);
            wr(4'd1, s0);
            wr(4'd0, 32'h3);
            strobe(k);
            rd(4'd1, v); chk("R5 random reload sequence", v, model_count(s0, ld, k));
        end
        wr(4'd0, 32'h0);
        wr(4'd5, 32'h7);

        // R11 correction disabled: plain periods
        wr(4'd6, 32'h2);
        wr(4'd8, 32'd232000);
        wr(4'd9, 32'hFFF4_4800);
        rd(4'd9, v); chk("R2 negative increment sign extended", v, 32'hFFF4_4800);
        wr(4'd2, 32'hFFFF_FFE0);
        wr(4'd1, 32'hFFFF_FFE0);
        wr(4'd0, 32'h3);
        run_periods(4);
        chk("R11 uncorrected period a", 32'(st[1] - st[0]), 32'd32);
        chk("R11 uncorrected period b", 32'(st[3] - st[2]), 32'd32);

        // R12 corrected 1 ms tick
        wr(4'd0, 32'h0);
        wr(4'd5, 32'h7);
        wr(4'd1, 32'hFFFF_FFE0);
        wr(4'd0, 32'h83);
        run_periods(1001);
        wr(4'd0, 32'h0);
        chk("R12 first period from start", 32'(st[0]), 32'd32);
        chk("R11 period after zero phase", 32'(st[1] - st[0]), 32'd32);
        chk("R11 stretched period", 32'(st[2] - st[1]), 32'd33);
        chk("R12 1000 periods total", 32'(st[1000] - st[0]), 32'd32768);

        report();
    end

endmodule